// File: doc/BRIEF.md
# Phase Comparison Coincidence Trip Logic

This block decides whether a line protection terminal trips or blocks. It compares the phase of the local line current with the phase seen at the remote terminals. The local current arrives as a square wave that is high during the positive half cycle. Each remote terminal arrives as a received level, where 1 means MARK and 0 means SPACE. While the fault-detector enable is high, the block counts how long the local wave and the remote levels agree, using a tick counter. It raises a trip request once that agreement has lasted for the programmed stability time. If the agreement is shorter, it holds a blocking indication instead. In-phase currents give almost full-half-cycle agreement and trip. Currents 180 degrees apart give almost no agreement and block.

A mode input selects a two-terminal or three-terminal line. A second mode input selects whether the positive or the negative half cycle is compared. Both mode inputs are captured only while the fault detector is dropped out. The setting is given in ticks. It is normally chosen so that the coincidence time lands between 3 and 4 ms for both line types.

The control state machine has three states:
- `ST_IDLE`: fault detector dropped out.
- `ST_ARMED`: comparing, blocking asserted.
- `ST_TRIP`: trip latched.

Its transitions are:
- `ST_IDLE`→`ST_ARMED` when the fault detector picks up.
- `ST_ARMED`→`ST_TRIP` when the integrator reaches the setting.
- `ST_ARMED`→`ST_IDLE` and `ST_TRIP`→`ST_IDLE` when the fault detector drops.

Top module: `phc_trip`

## Requirements
- R1: In positive mode (`neg_half` captured as 0), coincidence for one remote is `local_pos`=1 while that remote's level is 1 (MARK).
- R2: In negative mode (`neg_half` captured as 1), coincidence for one remote is `local_pos`=0 while that remote's level is 0 (SPACE).
- R3: The integrator counts ticked clock edges while coincidence holds and fd_en is high. Any edge without coincidence clears it to zero.
- R4: When the count equals the effective setting, the state moves to `ST_TRIP` on the next edge. With tick high and coincidence present from the edge at which fd_en is first seen high, `trip` reads 1 after setting+1 edges and 0 after setting edges.
- R5: A setting of 0 behaves exactly like a setting of 1.
- R6: With `three_term` captured as 1, coincidence requires both `rem_mark[0]` and `rem_mark[1]` to agree. With it captured as 0, `rem_mark[1]` has no effect.
- R7: An edge with fd_en low clears the integrator and returns the state to `ST_IDLE`, so after that edge `trip` and `block` are both 0.
- R8: Once `trip` is 1, it stays 1 on every edge at which fd_en is high, whatever the coincidence.
- R9: `three_term` and `neg_half` are captured only at edges with fd_en low. Changes to them while fd_en is high have no effect.
- R10: `block` is 1 exactly in `ST_ARMED`. `trip` and `block` are never 1 together.
- R11: After reset, the state is `ST_IDLE` with both outputs 0.
- R12: Edges with `tick` low never advance the integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Integrator time base enable |
| fd_en | input | 1 | Fault detector picked up; enables comparison |
| three_term | input | 1 | 1 = three-terminal line (two remotes) |
| neg_half | input | 1 | 1 = compare negative half cycle against SPACE |
| local_pos | input | 1 | Local square wave, 1 during positive half cycle |
| rem_mark | input | 2 | Received level per remote, 1 = MARK |
| setting | input | SET_W | Coincidence time in ticks (0 treated as 1) |
| trip | output | 1 | Latched trip request |
| block | output | 1 | Blocking indication while comparing |

## Verification
Several properties are checked on every cycle:
- the outputs are mutually exclusive;
- a dropped fault detector clears the outputs;
- the trip latches while the detector stays up;
- the integrator clears on lost coincidence and advances only on ticked coincidence;
- the captured mode holds steady during a comparison;
- every trip is preceded by a reached count.

Only the bench scenarios can show the coincidence truth table in each half-cycle and line mode. They also cover:
- the exact edge on which trip appears for a given setting;
- the equivalence of settings 0 and 1;
- the blocking result for antiphase currents;
- the effect of a single-edge gap in coincidence.

// File: rtl/phc_pkg.sv
package phc_pkg;

    // Number of remote terminals the coincidence stage can combine
    localparam int N_REMOTE = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRIP  = 2'd2
    } phc_state_e;

    // Comparison mode, captured while the fault detector is dropped out
    typedef struct packed {
        logic three_term;
        logic neg_half;
    } phc_mode_t;

endpackage

// File: rtl/phc_mode_reg.sv
module phc_mode_reg
    import phc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fd_en,
    input  logic      three_term_in,
    input  logic      neg_half_in,
    output phc_mode_t mode_q
);

    // R9: capture only while no comparison is running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (!fd_en) begin
            mode_q.three_term <= three_term_in;
            mode_q.neg_half   <= neg_half_in;
        end
    end

endmodule

// File: rtl/phc_coinc.sv
module phc_coinc
    import phc_pkg::*;
(
    input  phc_mode_t             mode,
    input  logic                  local_pos,
    input  logic [N_REMOTE-1:0]   rem_mark,
    output logic                  coin
);

    logic                local_active;
    logic [N_REMOTE-1:0] rem_match;
    logic [N_REMOTE-1:0] rem_used;
    logic [N_REMOTE-1:0] rem_ok;

    // R1/R2: the half cycle and the expected received level flip together
    assign local_active = mode.neg_half ? ~local_pos : local_pos;

    for (genvar g = 0; g < N_REMOTE; g++) begin : g_remote
        assign rem_match[g] = mode.neg_half ? ~rem_mark[g] : rem_mark[g];
        if (g == 0) begin : g_first
            assign rem_used[g] = 1'b1;
        end else begin : g_extra
            // R6: further remotes count only on a three-terminal line
            assign rem_used[g] = mode.three_term;
        end
        assign rem_ok[g] = rem_match[g] | ~rem_used[g];
    end

    assign coin = local_active & (&rem_ok);

endmodule

// File: rtl/phc_integ.sv
module phc_integ #(
    parameter int SET_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fd_en,
    input  logic             coin,
    input  logic             tick,
    input  logic [SET_W-1:0] setting,
    output logic [SET_W-1:0] cnt,
    output logic             reached
);

    localparam logic [SET_W-1:0] MIN_SET = SET_W'(1);

    logic [SET_W-1:0] limit;

    // R5: zero setting is raised to the one-tick minimum
    assign limit = (setting == '0) ? MIN_SET : setting;

    // R3/R7/R12: counter of ticked coincidence, cleared otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!fd_en || !coin) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + MIN_SET;
        end
    end

    assign reached = (cnt >= limit);

endmodule

// File: rtl/phc_fsm.sv
module phc_fsm
    import phc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fd_en,
    input  logic       reached,
    output phc_state_e state,
    output logic       trip,
    output logic       block
);

    phc_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (fd_en) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (!fd_en)       state_nx = ST_IDLE;
                else if (reached) state_nx = ST_TRIP;
            end
            ST_TRIP: begin
                if (!fd_en) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        trip  = 1'b0;
        block = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: block = 1'b1;
            ST_TRIP:  trip  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/phc_trip.sv
module phc_trip
    import phc_pkg::*;
#(
    parameter int SET_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                fd_en,
    input  logic                three_term,
    input  logic                neg_half,
    input  logic                local_pos,
    input  logic [1:0]          rem_mark,
    input  logic [SET_W-1:0]    setting,
    output logic                trip,
    output logic                block
);

    phc_mode_t        mode_q;
    logic             coin;
    logic [SET_W-1:0] cnt;
    logic             reached;
    phc_state_e       state;

    phc_mode_reg u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .fd_en         (fd_en),
        .three_term_in (three_term),
        .neg_half_in   (neg_half),
        .mode_q        (mode_q)
    );

    phc_coinc u_coinc (
        .mode      (mode_q),
        .local_pos (local_pos),
        .rem_mark  (rem_mark),
        .coin      (coin)
    );

    phc_integ #(.SET_W(SET_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .fd_en   (fd_en),
        .coin    (coin),
        .tick    (tick),
        .setting (setting),
        .cnt     (cnt),
        .reached (reached)
    );

    phc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fd_en   (fd_en),
        .reached (reached),
        .state   (state),
        .trip    (trip),
        .block   (block)
    );

endmodule

// File: rtl/phc_trip_chk.sv
module phc_trip_chk #(
    parameter int SET_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             fd_en,
    input logic             trip,
    input logic             block,
    input logic [1:0]       mode_bits,
    input logic             coin,
    input logic [SET_W-1:0] cnt,
    input logic             reached
);

    assert_out_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trip && block));

    assert_fd_drop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fd_en |=> (!trip && !block));

    assert_trip_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && fd_en) |=> trip);

    assert_trip_after_reach_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> $past(reached));

    assert_gap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_en && !coin) |=> (cnt == '0));

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fd_en |=> $stable(mode_bits));

    assert_tick_gates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > $past(cnt)) |-> $past(tick && coin && fd_en));

endmodule

bind phc_trip phc_trip_chk #(.SET_W(SET_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .fd_en     (fd_en),
    .trip      (trip),
    .block     (block),
    .mode_bits (mode_q),
    .coin      (coin),
    .cnt       (cnt),
    .reached   (reached)
);

// File: tb/phc_trip_tb.sv
module phc_trip_tb_top;

    localparam int SET_W = 16;

    typedef struct packed {
        logic [3:0] req;
        logic       three;
        logic       neg;
        logic       loc;
        logic       ra;
        logic       rb;
        logic [7:0] set;
        logic [7:0] edges;
        logic       etrip;
        logic       eblock;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4, 8'd4, 1'b0, 1'b1},
        '{4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4, 8'd5, 1'b1, 1'b0},
        '{4'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 8'd6, 1'b0, 1'b1},
        '{4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 8'd4, 1'b1, 1'b0},
        '{4'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2, 8'd6, 1'b0, 1'b1},
        '{4'd2,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2, 8'd6, 1'b0, 1'b1},
        '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2, 8'd5, 1'b0, 1'b1},
        '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd2, 8'd3, 1'b1, 1'b0},
        '{4'd6,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 8'd3, 1'b1, 1'b0},
        '{4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd1, 1'b0, 1'b1},
        '{4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd2, 1'b1, 1'b0},
        '{4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 8'd2, 1'b1, 1'b0},
        '{4'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd2, 8'd6, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b1;
    logic             fd_en = 1'b0;
    logic             three_term = 1'b0;
    logic             neg_half = 1'b0;
    logic             local_pos = 1'b0;
    logic [1:0]       rem_mark = 2'b00;
    logic [SET_W-1:0] setting = '0;
    logic             trip;
    logic             block;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phc_trip #(.SET_W(SET_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fd_en      (fd_en),
        .three_term (three_term),
        .neg_half   (neg_half),
        .local_pos  (local_pos),
        .rem_mark   (rem_mark),
        .setting    (setting),
        .trip       (trip),
        .block      (block)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic exp_trip, input logic exp_block);
        n_chk++;
        if (trip !== exp_trip || block !== exp_block) begin
            n_bad++;
            $display("FAIL %s: trip/block actual %b%b expected %b%b",
                     req, trip, block, exp_trip, exp_block);
        end
    endtask

    // One edge with fd_en low to capture the mode and return to idle
    task automatic rearm(input logic th, input logic ng);
        @(negedge clk);
        fd_en      = 1'b0;
        three_term = th;
        neg_half   = ng;
        tick       = 1'b1;
        @(negedge clk);
    endtask

    task automatic start(input logic lp, input logic [1:0] rm, input int s);
        local_pos = lp;
        rem_mark  = rm;
        setting   = SET_W'(s);
        fd_en     = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 1'b0, 1'b0);

        // R7: coincidence present but fault detector dropped out
        local_pos = 1'b1; rem_mark = 2'b11; setting = SET_W'(1);
        repeat (4) @(negedge clk);
        check("R7", 1'b0, 1'b0);

        // Vector table; R10: block and trip exclusive in every row
        for (int i = 0; i < NV; i++) begin
            rearm(VECS[i].three, VECS[i].neg);
            start(VECS[i].loc, {VECS[i].rb, VECS[i].ra}, int'(VECS[i].set));
            repeat (int'(VECS[i].edges)) @(negedge clk);
            check(req_name(VECS[i].req), VECS[i].etrip, VECS[i].eblock);
        end

        // R8: trip holds after coincidence is lost
        rearm(1'b0, 1'b0);
        start(1'b1, 2'b01, 2);
        repeat (3) @(negedge clk);
        check("R4", 1'b1, 1'b0);
        local_pos = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", 1'b1, 1'b0);
        // R7: dropping the detector clears the trip after one edge
        fd_en = 1'b0;
        @(negedge clk);
        check("R7", 1'b0, 1'b0);

        // R3: a one-edge gap restarts the count
        rearm(1'b0, 1'b0);
        start(1'b1, 2'b01, 4);
        repeat (3) @(negedge clk);
        local_pos = 1'b0;
        @(negedge clk);
        local_pos = 1'b1;
        repeat (4) @(negedge clk);
        check("R3", 1'b0, 1'b1);
        @(negedge clk);
        check("R3", 1'b1, 1'b0);

        // R9: mode change while comparing is ignored
        rearm(1'b0, 1'b0);
        start(1'b1, 2'b01, 2);
        neg_half   = 1'b1;
        three_term = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", 1'b1, 1'b0);

        // R12: no ticks, no progress
        rearm(1'b0, 1'b0);
        start(1'b1, 2'b01, 1);
        tick = 1'b0;
        repeat (6) @(negedge clk);
        check("R12", 1'b0, 1'b1);
        tick = 1'b1;
        repeat (2) @(negedge clk);
        check("R12", 1'b1, 1'b0);

        // R6: in two-terminal mode the second remote is ignored
        rearm(1'b0, 1'b0);
        start(1'b1, 2'b11, 2);
        @(negedge clk);
        rem_mark = 2'b01;
        repeat (2) @(negedge clk);
        check("R6", 1'b1, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule